// File: doc/BRIEF.md
# Embedded Controller Host Mailbox Port

This block is the device side of the byte-wide host interface of an ACPI embedded controller. The host sees three byte locations on a generic strobe bus: a data port, a location that reads as status and accepts commands when written, and an interrupt-control byte. Two handshake flags govern the traffic. The input-busy flag (IBF) means that a byte is waiting for the controller. The output-full flag (OBF) means that a byte is waiting for the host. Before each write the host waits for the input-busy flag to clear, and before reading the data port it waits for the output-full flag to set.

Each byte written to the data or command port is held for a fixed processing delay of `PROC_CYC` cycles and then consumed by a sequencer. A read command followed by an address byte fetches one byte from a 256-location internal register space through a synchronous read/write port and places it in the output buffer. A write command followed by an address byte and a data byte stores the data byte in that space. Other commands switch burst mode on or off, or query the lowest-numbered pending event. Events are raised by pulses on `evt_raise`. While any event is pending, a flag is presented as either an SCI or an SMI request, chosen by bit 0 of the interrupt-control byte.

The sequencer states are ST_IDLE, ST_RD_ADDR, ST_RD_WAIT, ST_WR_ADDR and ST_WR_DATA. Any processed command byte first overrides the current state: a read command goes to ST_RD_ADDR, a write command goes to ST_WR_ADDR, and every other code goes to ST_IDLE. A processed data byte moves ST_RD_ADDR to ST_RD_WAIT (register read strobe), ST_WR_ADDR to ST_WR_DATA (address latched), and ST_WR_DATA to ST_IDLE (register write strobe). ST_RD_WAIT always returns to ST_IDLE after one cycle, loading the output buffer. A data byte processed in ST_IDLE leaves the state unchanged.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte, the interrupt-control byte and the data port all read 0x00, and no register strobe has fired.
- R2: A host write to offset 0x0 (data) or 0x4 (command) sets status bit 1 (IBF) from the next cycle for exactly `PROC_CYC` cycles, after which it clears; a write to offset 0x8 does not set it.
- R3: Status bit 3 (CMD) is set by a write to offset 0x4 and cleared by a write to offset 0x0.
- R4: Command 0x80 followed by an address byte pulses `reg_re` with that address; two cycles later the byte returned on `reg_rdata` is in the output buffer and status bit 0 (OBF) is set.
- R5: A host read of offset 0x0 returns the output buffer and clears OBF.
- R6: Command 0x81 followed by an address byte and a data byte gives exactly one `reg_we` pulse carrying that address and data.
- R7: Command 0x82 sets status bit 4 (burst), and command 0x83 clears it.
- R8: Command 0x84 loads the output buffer with the code of the lowest-numbered pending event (event bit i has code i+1), or 0x00 if no event is pending, sets OBF, and clears that event.
- R9: While any event is pending, status bit 5 and `sci_pend` are set if interrupt-control bit 0 is 0, and status bit 6 and `smi_pend` are set if it is 1; both clear once no event remains.
- R10: A command byte that arrives in the middle of a read or write sequence abandons that sequence, and the following data bytes follow the new command.
- R11: An unrecognised command code causes no register strobe and leaves OBF, the output buffer and burst mode unchanged; like any other command, it ends a sequence that is in progress.
- R12: A data byte processed while no sequence is active causes no register strobe and does not set OBF.
- R13: Offset 0x8 reads back the last value written to it, and reads of other unused offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe, one cycle per byte |
| hst_rd | input | 1 | Host read strobe, one cycle per byte |
| hst_addr | input | 4 | Host byte offset (0x0 data, 0x4 status/command, 0x8 interrupt control) |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, valid in the cycle of `hst_rd` |
| reg_re | output | 1 | Internal register space read strobe |
| reg_we | output | 1 | Internal register space write strobe |
| reg_addr | output | 8 | Internal register space address |
| reg_wdata | output | 8 | Internal register space write data |
| reg_rdata | input | 8 | Internal register space read data, one cycle after `reg_re` |
| evt_raise | input | NEVT | One pulse per event bit marks that event pending |
| sci_pend | output | 1 | Event pending, routed to SCI |
| smi_pend | output | 1 | Event pending, routed to SMI |

## Verification
On every cycle, the assertions check that a data or command write raises the input-busy flag and that a strobe toward the register space only occurs while a byte is being consumed. They also check that read and write strobes never coincide, that a read strobe is followed two cycles later by a full output buffer, that the output-full flag only falls after a host read of the data port, and that SCI and SMI are never requested together. The exact length of the busy window, the full read and write command sequences over every register address, aborted sequences, ignored command and data bytes, and the query priority over every pattern of eight events can only be shown by the bench scenarios, which compare the results with an address-derived data pattern and a bench-side lowest-bit search.

// File: rtl/ec_pkg.sv
package ec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_WAIT,
        ST_WR_ADDR,
        ST_WR_DATA
    } seq_state_e;

    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;

    localparam logic [3:0] OFS_DATA = 4'h0;
    localparam logic [3:0] OFS_CTRL = 4'h4;
    localparam logic [3:0] OFS_ICR  = 4'h8;

endpackage

// File: rtl/ec_ibf_timer.sv
// Holds the last host byte and keeps the busy flag up for PROC_CYC cycles.
module ec_ibf_timer #(
    parameter int PROC_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data,
    input  logic       wr_cmd,
    input  logic [7:0] wdata,
    output logic       ibf,
    output logic       is_cmd,
    output logic [7:0] in_byte,
    output logic       proc
);
    localparam int CW = $clog2(PROC_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf     <= 1'b0;
            cnt_q   <= '0;
            is_cmd  <= 1'b0;
            in_byte <= '0;
        end else if (wr_data || wr_cmd) begin
            ibf     <= 1'b1;
            cnt_q   <= CW'(PROC_CYC - 1);
            in_byte <= wdata;
            is_cmd  <= wr_cmd;
        end else if (ibf) begin
            if (cnt_q == '0) begin
                ibf <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // the byte is consumed in the last busy cycle
    assign proc = ibf && (cnt_q == '0);

endmodule

// File: rtl/ec_evt_queue.sv
// Pending event bits with a lowest-index-first pick for the query command.
module ec_evt_queue #(
    parameter int NEVT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] raise,
    input  logic            take,
    output logic            any,
    output logic [7:0]      code
);
    logic [NEVT-1:0] pend_q;
    logic [NEVT-1:0] low_mask;

    always_comb begin
        code     = '0;
        low_mask = '0;
        for (int i = NEVT - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                code        = 8'(i + 1);
                low_mask    = '0;
                low_mask[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            // a new raise wins over a clear in the same cycle
            pend_q <= (pend_q & ~(take ? low_mask : '0)) | raise;
        end
    end

    assign any = |pend_q;

endmodule

// File: rtl/ec_seq_fsm.sv
// Command sequencer: decodes command bytes, walks address/data bytes.
module ec_seq_fsm
    import ec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc,
    input  logic       is_cmd,
    input  logic [7:0] in_byte,
    input  logic [7:0] reg_rdata,
    input  logic [7:0] evt_code,
    input  logic       host_rd_data,
    output logic       reg_re,
    output logic       reg_we,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       evt_take,
    output logic [7:0] obuf,
    output logic       obf,
    output logic       burst
);
    seq_state_e st_q, st_nx;
    logic [7:0] addr_q;
    logic       cmd_go;
    logic       data_go;

    assign cmd_go  = proc && is_cmd;
    assign data_go = proc && !is_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    always_comb begin
        st_nx = st_q;
        if (cmd_go) begin
            if (in_byte == OP_READ) begin
                st_nx = ST_RD_ADDR;
            end else if (in_byte == OP_WRITE) begin
                st_nx = ST_WR_ADDR;
            end else begin
                st_nx = ST_IDLE;
            end
        end else begin
            unique case (st_q)
                ST_IDLE:    st_nx = ST_IDLE;
                ST_RD_ADDR: if (data_go) st_nx = ST_RD_WAIT;
                ST_RD_WAIT: st_nx = ST_IDLE;
                ST_WR_ADDR: if (data_go) st_nx = ST_WR_DATA;
                ST_WR_DATA: if (data_go) st_nx = ST_IDLE;
                default:    st_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        reg_re    = data_go && (st_q == ST_RD_ADDR);
        reg_we    = data_go && (st_q == ST_WR_DATA);
        reg_addr  = (st_q == ST_WR_DATA) ? addr_q : in_byte;
        reg_wdata = in_byte;
        evt_take  = cmd_go && (in_byte == OP_QUERY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            obuf   <= '0;
            obf    <= 1'b0;
            burst  <= 1'b0;
        end else begin
            if (data_go && (st_q == ST_WR_ADDR)) begin
                addr_q <= in_byte;
            end
            if (st_q == ST_RD_WAIT) begin
                obuf <= reg_rdata;
                obf  <= 1'b1;
            end else if (evt_take) begin
                obuf <= evt_code;
                obf  <= 1'b1;
            end else if (host_rd_data) begin
                obf <= 1'b0;
            end
            if (cmd_go && (in_byte == OP_BURST_ON)) begin
                burst <= 1'b1;
            end else if (cmd_go && (in_byte == OP_BURST_OFF)) begin
                burst <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_pkg::*;
#(
    parameter int PROC_CYC = 3,
    parameter int NEVT     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hst_wr,
    input  logic            hst_rd,
    input  logic [3:0]      hst_addr,
    input  logic [7:0]      hst_wdata,
    output logic [7:0]      hst_rdata,
    output logic            reg_re,
    output logic            reg_we,
    output logic [7:0]      reg_addr,
    output logic [7:0]      reg_wdata,
    input  logic [7:0]      reg_rdata,
    input  logic [NEVT-1:0] evt_raise,
    output logic            sci_pend,
    output logic            smi_pend
);
    logic       wr_data, wr_cmd, wr_icr, host_rd_data;
    logic       ibf, is_cmd, proc;
    logic [7:0] in_byte;
    logic       evt_take, evt_any;
    logic [7:0] evt_code;
    logic [7:0] obuf;
    logic       obf, burst;
    logic [7:0] icr_q;
    logic [7:0] status;

    assign wr_data      = hst_wr && (hst_addr == OFS_DATA);
    assign wr_cmd       = hst_wr && (hst_addr == OFS_CTRL);
    assign wr_icr       = hst_wr && (hst_addr == OFS_ICR);
    assign host_rd_data = hst_rd && (hst_addr == OFS_DATA);

    ec_ibf_timer #(.PROC_CYC(PROC_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .wr_cmd  (wr_cmd),
        .wdata   (hst_wdata),
        .ibf     (ibf),
        .is_cmd  (is_cmd),
        .in_byte (in_byte),
        .proc    (proc)
    );

    ec_evt_queue #(.NEVT(NEVT)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (evt_raise),
        .take  (evt_take),
        .any   (evt_any),
        .code  (evt_code)
    );

    ec_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .proc         (proc),
        .is_cmd       (is_cmd),
        .in_byte      (in_byte),
        .reg_rdata    (reg_rdata),
        .evt_code     (evt_code),
        .host_rd_data (host_rd_data),
        .reg_re       (reg_re),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .evt_take     (evt_take),
        .obuf         (obuf),
        .obf          (obf),
        .burst        (burst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icr_q <= '0;
        end else if (wr_icr) begin
            icr_q <= hst_wdata;
        end
    end

    assign sci_pend = evt_any && !icr_q[0];
    assign smi_pend = evt_any && icr_q[0];
    assign status   = {1'b0, smi_pend, sci_pend, burst, is_cmd, 1'b0, ibf, obf};

    always_comb begin
        hst_rdata = '0;
        if (hst_rd) begin
            case (hst_addr)
                OFS_DATA: hst_rdata = obuf;
                OFS_CTRL: hst_rdata = status;
                OFS_ICR:  hst_rdata = icr_q;
                default:  hst_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hst_wr,
    input logic       hst_rd,
    input logic [3:0] hst_addr,
    input logic       reg_re,
    input logic       reg_we,
    input logic       sci_pend,
    input logic       smi_pend,
    input logic       ibf,
    input logic       obf
);
    // R2: data or command write raises the busy flag
    a_r2_ibf_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && (hst_addr == 4'h0 || hst_addr == 4'h4)) |=> ibf);

    // R2: a write to interrupt control does not raise an idle busy flag
    a_r2_icr_no_ibf: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr == 4'h8 && !ibf) |=> !ibf);

    // R6, R12: register strobes only while a byte is being consumed
    a_r6_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> ibf);

    // R6: read and write strobes never together
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re}));

    // R4: fetched byte reaches the output buffer two cycles after the strobe
    a_r4_fetch_fills: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> ##2 obf);

    // R5: output-full only falls after a host data read
    a_r5_obf_fall_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf) |-> $past(hst_rd && hst_addr == 4'h0));

    // R9: one route only
    a_r9_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sci_pend && smi_pend));

endmodule

bind ec_host_port ec_host_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hst_wr   (hst_wr),
    .hst_rd   (hst_rd),
    .hst_addr (hst_addr),
    .reg_re   (reg_re),
    .reg_we   (reg_we),
    .sci_pend (sci_pend),
    .smi_pend (smi_pend),
    .ibf      (ibf),
    .obf      (obf)
);

// File: tb/tb_ec_host_port.sv
`timescale 1ns/1ps
module tb_ec_host_port;
    localparam int PROC_CYC = 3;
    localparam int NEVT     = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hst_wr = 1'b0;
    logic            hst_rd = 1'b0;
    logic [3:0]      hst_addr = '0;
    logic [7:0]      hst_wdata = '0;
    logic [7:0]      hst_rdata;
    logic            reg_re, reg_we;
    logic [7:0]      reg_addr, reg_wdata;
    logic [7:0]      reg_rdata = '0;
    logic [NEVT-1:0] evt_raise = '0;
    logic            sci_pend, smi_pend;

    int nchk = 0;
    int nerr = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    logic [7:0] mem [256];

    always #4 clk = ~clk;

    ec_host_port #(.PROC_CYC(PROC_CYC), .NEVT(NEVT)) dut (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .reg_re(reg_re), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_raise(evt_raise), .sci_pend(sci_pend), .smi_pend(smi_pend)
    );

    // bench-side register space
    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (reg_re) reg_rdata <= mem[reg_addr];
        if (rst_n && reg_we) we_cnt <= we_cnt + 1;
        if (rst_n && reg_re) re_cnt <= re_cnt + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] lowest_code(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return 8'(i + 1);
        return 8'h00;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic wait_flag(input int bitn, input logic val, input string req);
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            hread(4'h4, s);
            if (s[bitn] == val) return;
        end
        check(req, 0, 1);
    endtask

    task automatic send(input logic [3:0] a, input logic [7:0] d);
        wait_flag(1, 1'b0, "R2");
        hwrite(a, d);
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
        send(4'h4, 8'h81);
        send(4'h0, a);
        send(4'h0, d);
        wait_flag(1, 1'b0, "R6");
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] d);
        send(4'h4, 8'h80);
        send(4'h0, a);
        wait_flag(0, 1'b1, "R4");
        hread(4'h0, d);
    endtask

    task automatic query(output logic [7:0] d);
        send(4'h4, 8'h84);
        wait_flag(0, 1'b1, "R8");
        hread(4'h0, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] s, d, m, c;
        int w0, r0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hread(4'h4, s); check("R1 status", s, 8'h00);
        hread(4'h8, s); check("R1 icr", s, 8'h00);
        hread(4'h0, s); check("R1 data", s, 8'h00);
        check("R1 strobes", we_cnt + re_cnt, 0);

        // R2 busy window length, R11 unknown command, R3 CMD flag
        hwrite(4'h4, 8'h5A);
        for (int i = 0; i < PROC_CYC; i++) begin
            hst_addr = 4'h4; hst_rd = 1'b1;
            #1 check("R2 ibf high", hst_rdata[1], 1);
            if (i == 0) check("R3 cmd set", hst_rdata[3], 1);
            @(negedge clk);
        end
        hst_addr = 4'h4; hst_rd = 1'b1;
        #1 check("R2 ibf cleared", hst_rdata[1], 0);
        check("R11 no obf", hst_rdata[0], 0);
        check("R11 no burst", hst_rdata[4], 0);
        @(negedge clk); hst_rd = 1'b0;
        check("R11 no strobe", we_cnt + re_cnt, 0);

        // R13 / R2: interrupt-control byte
        hwrite(4'h8, 8'hA4);
        hread(4'h4, s); check("R2 icr write no ibf", s[1], 0);
        hread(4'h8, s); check("R13 icr readback", s, 8'hA4);
        hread(4'hC, s); check("R13 unused offset", s, 8'h00);
        hwrite(4'h8, 8'h00);

        // R6 write sweep over the whole register space
        for (int a = 0; a < 256; a++) begin
            ec_write(8'(a), pat(a));
            check("R6 stored", mem[a], pat(a));
        end
        check("R6 one strobe each", we_cnt, 256);

        // R4 / R5 read sweep
        for (int a = 0; a < 256; a++) begin
            ec_read(8'(a), d);
            check("R4 read data", d, pat(a));
            hread(4'h4, s);
            check("R5 obf cleared", s[0], 0);
        end
        check("R4 one strobe each", re_cnt, 256);

        // R3 / R12: data byte with no sequence
        w0 = we_cnt; r0 = re_cnt;
        send(4'h4, 8'h83);
        wait_flag(1, 1'b0, "R2");
        send(4'h0, 8'h12);
        hread(4'h4, s); check("R3 cmd cleared", s[3], 0);
        wait_flag(1, 1'b0, "R2");
        hread(4'h4, s); check("R12 no obf", s[0], 0);
        check("R12 no strobe", we_cnt + re_cnt, w0 + r0);

        // R7 burst on/off
        send(4'h4, 8'h82); wait_flag(1, 1'b0, "R2");
        hread(4'h4, s); check("R7 burst on", s[4], 1);
        send(4'h4, 8'h83); wait_flag(1, 1'b0, "R2");
        hread(4'h4, s); check("R7 burst off", s[4], 0);

        // R10 write abandoned by a read command
        w0 = we_cnt;
        send(4'h4, 8'h81); send(4'h0, 8'h10);
        ec_read(8'h20, d);
        check("R10 new read data", d, pat(32));
        check("R10 old target kept", mem[16], pat(16));
        check("R10 no write strobe", we_cnt, w0);

        // R11 unknown command mid-sequence
        send(4'h4, 8'h81); send(4'h0, 8'h30);
        send(4'h4, 8'h77); send(4'h0, 8'hAA);
        wait_flag(1, 1'b0, "R2");
        check("R11 target kept", mem[48], pat(48));
        check("R11 no write strobe", we_cnt, w0);
        hread(4'h4, s); check("R11 flags kept", s & 8'h11, 8'h00);

        // R8 / R9 query sweep over all event patterns
        for (int p = 0; p < 256; p++) begin
            logic route;
            route = (p % 3 == 0);
            hwrite(4'h8, {7'd0, route});
            @(negedge clk); evt_raise = 8'(p);
            @(negedge clk); evt_raise = '0;
            hread(4'h4, s);
            check("R9 sci flag", s[5], (p != 0) && !route);
            check("R9 smi flag", s[6], (p != 0) && route);
            check("R9 ports", {sci_pend, smi_pend}, {(p != 0) && !route, (p != 0) && route});
            m = 8'(p);
            for (int n = 0; n < 10; n++) begin
                query(c);
                check("R8 query code", c, lowest_code(m));
                if (c == 8'h00) break;
                m = m & (m - 8'd1);
            end
            hread(4'h4, s);
            check("R9 flags cleared", s & 8'h60, 8'h00);
        end
        hwrite(4'h8, 8'h00);

        summary();
        $finish;
    end

endmodule